// File: doc/BRIEF.md
# TFT Display Timing Generator

This block sequences the raster of a TFT panel. It runs on the pixel clock and advances one pixel per cycle. A horizontal phase machine steps through sync, back porch, active and front porch. A vertical phase machine does the same, but moves one line each time a horizontal line completes. Each phase lasts its configured value plus one, so a field value of zero still gives one cycle or one line.

The block drives the following outputs:
- horizontal sync, vertical sync, data-enable and a line-end pulse;
- a pass-through of the pixel data word;
- a flag for the pixel clock launch edge;
- a two-bit phase status for each axis;
- pixel coordinates and a data-valid strobe.

The sync, data, data-enable and line-end outputs each have their own polarity inversion bit. The line-end pulse has an enable bit.

All configuration arrives on plain input ports. This covers the phase lengths, the polarity bits, the line-end enable and the edge select. The block captures the configuration only at reset and at the frame boundary, so a change made in mid-frame never tears the frame in progress.

Top module: `tft_timing_gen`

## Requirements
- R1: While the synchronous active-low reset is applied, both axes sit at the start of their sync phase with count 0, so hstat_o and vstat_o read 0, and the configuration inputs are captured.
- R2: The horizontal phases run in the order sync, back porch, active, front porch, then sync again. Each phase lasts its length field plus 1 clock cycles. The horizontal sync length field is 8 bits wide, and the value 255 gives 256 cycles.
- R3: hstat_o and vstat_o encode the current phase of their axis as 0 for sync, 1 for back porch, 2 for active and 3 for front porch.
- R4: The vertical phase machine advances one line per completed horizontal line, at the cycle where the horizontal front porch wraps to sync. Each vertical phase lasts its length field plus 1 lines.
- R5: hsync_o is 1 during the horizontal sync phase and 0 elsewhere, XOR the captured inv_hsync. vsync_o follows the same rule for the vertical sync phase and inv_vsync.
- R6: den_o is 1 exactly when both axes are in the active phase, XOR the captured inv_den.
- R7: pix_valid_o is 1 exactly when both axes are active, and no polarity bit changes it. While it is 1, px_x_o gives the pixel index within the active part of the line, starting at 0, and px_y_o gives the active line index, starting at 0.
- R8: pix_data_o equals pix_data_i with every bit XORed with the captured inv_data.
- R9: When the captured lend_en is 1, lend_o is 1 XOR inv_lend for the single first cycle of each horizontal front porch, on every line, and 0 XOR inv_lend otherwise. When lend_en is 0, lend_o is 0.
- R10: pclk_fall_o equals the captured pclk_fall_sel. A value of 1 means video data is launched on the falling pixel clock edge, and 0 means the rising edge.
- R11: Configuration inputs take effect only from the frame boundary. This is the clock edge at which the last front-porch line's last front-porch pixel ends and both axes return to sync with count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_hsync_len | input | SW | Horizontal sync length minus 1, in clocks |
| cfg_hback_len | input | CW | Horizontal back porch length minus 1 |
| cfg_hact_len | input | CW | Horizontal active length minus 1 |
| cfg_hfront_len | input | CW | Horizontal front porch length minus 1 |
| cfg_vsync_len | input | CW | Vertical sync length minus 1, in lines |
| cfg_vback_len | input | CW | Vertical back porch length minus 1 |
| cfg_vact_len | input | CW | Vertical active length minus 1 |
| cfg_vfront_len | input | CW | Vertical front porch length minus 1 |
| inv_hsync | input | 1 | Invert horizontal sync |
| inv_vsync | input | 1 | Invert vertical sync |
| inv_data | input | 1 | Invert pixel data |
| inv_den | input | 1 | Invert data-enable |
| inv_lend | input | 1 | Invert line-end |
| lend_en | input | 1 | Enable the line-end pulse |
| pclk_fall_sel | input | 1 | 1 selects a falling-edge data launch |
| pix_data_i | input | DW | Pixel data in |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| den_o | output | 1 | Data-enable |
| lend_o | output | 1 | Line-end pulse |
| pclk_fall_o | output | 1 | Captured launch-edge select |
| pix_data_o | output | DW | Pixel data out, polarity applied |
| hstat_o | output | 2 | Horizontal phase status |
| vstat_o | output | 2 | Vertical phase status |
| pix_valid_o | output | 1 | Both axes active |
| px_x_o | output | CW | Active pixel column |
| px_y_o | output | CW | Active line row |

## Verification
The bench changes the configuration inputs at random points in mid-frame. A design that applies a new length or polarity at once, instead of at the frame boundary, shows a phase boundary or output level in the wrong cycle. All-zero lengths make every phase a single cycle, which exposes off-by-one counting and a vertical step taken on the wrong horizontal phase. A sync length of 255 catches a sync counter that is truncated or compared at the wrong width. The bench sets the line-end enable and inversion bits in every combination, which catches a pulse that leaks out while disabled or that fires only on active lines.

// File: rtl/tft_timing_gen.sv
module tft_timing_gen #(
  parameter int SW = 8,
  parameter int CW = 11,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] cfg_hsync_len,
  input  logic [CW-1:0] cfg_hback_len,
  input  logic [CW-1:0] cfg_hact_len,
  input  logic [CW-1:0] cfg_hfront_len,
  input  logic [CW-1:0] cfg_vsync_len,
  input  logic [CW-1:0] cfg_vback_len,
  input  logic [CW-1:0] cfg_vact_len,
  input  logic [CW-1:0] cfg_vfront_len,
  input  logic          inv_hsync,
  input  logic          inv_vsync,
  input  logic          inv_data,
  input  logic          inv_den,
  input  logic          inv_lend,
  input  logic          lend_en,
  input  logic          pclk_fall_sel,
  input  logic [DW-1:0] pix_data_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          den_o,
  output logic          lend_o,
  output logic          pclk_fall_o,
  output logic [DW-1:0] pix_data_o,
  output logic [1:0]    hstat_o,
  output logic [1:0]    vstat_o,
  output logic          pix_valid_o,
  output logic [CW-1:0] px_x_o,
  output logic [CW-1:0] px_y_o
);
  localparam logic [1:0] PH_SYNC = 2'd0, PH_BACK = 2'd1, PH_ACT = 2'd2, PH_FRONT = 2'd3;
  localparam int NPOL = 7;
  localparam int CFGW = SW + 7 * CW + NPOL;

  logic [SW-1:0] hs_q;
  logic [CW-1:0] hb_q, ha_q, hf_q, vs_q, vb_q, va_q, vf_q;
  logic [NPOL-1:0] pol_q;
  logic [NPOL-1:0] pol_in;
  logic [1:0] hph, vph;
  logic [CW-1:0] hcnt, vcnt, hlen, vlen;
  logic h_last, v_last, line_end, frame_end, both_act;
  logic [CFGW-1:0] cfg_all;

  assign pol_in = {inv_hsync, inv_vsync, inv_data, inv_den, inv_lend, lend_en, pclk_fall_sel};

  always_comb begin
    case (hph)
      PH_SYNC: hlen = {{(CW-SW){1'b0}}, hs_q};
      PH_BACK: hlen = hb_q;
      PH_ACT:  hlen = ha_q;
      default: hlen = hf_q;
    endcase
    case (vph)
      PH_SYNC: vlen = vs_q;
      PH_BACK: vlen = vb_q;
      PH_ACT:  vlen = va_q;
      default: vlen = vf_q;
    endcase
  end

  assign h_last    = (hcnt == hlen);
  assign v_last    = (vcnt == vlen);
  assign line_end  = h_last && (hph == PH_FRONT);
  assign frame_end = line_end && v_last && (vph == PH_FRONT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hph <= PH_SYNC;
      vph <= PH_SYNC;
      hcnt <= '0;
      vcnt <= '0;
      hs_q <= cfg_hsync_len;
      hb_q <= cfg_hback_len;
      ha_q <= cfg_hact_len;
      hf_q <= cfg_hfront_len;
      vs_q <= cfg_vsync_len;
      vb_q <= cfg_vback_len;
      va_q <= cfg_vact_len;
      vf_q <= cfg_vfront_len;
      pol_q <= pol_in;
    end else begin
      if (h_last) begin
        hcnt <= '0;
        hph <= hph + 2'd1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
      if (line_end) begin
        if (v_last) begin
          vcnt <= '0;
          vph <= vph + 2'd1;
        end else begin
          vcnt <= vcnt + 1'b1;
        end
      end
      if (frame_end) begin
        hs_q <= cfg_hsync_len;
        hb_q <= cfg_hback_len;
        ha_q <= cfg_hact_len;
        hf_q <= cfg_hfront_len;
        vs_q <= cfg_vsync_len;
        vb_q <= cfg_vback_len;
        va_q <= cfg_vact_len;
        vf_q <= cfg_vfront_len;
        pol_q <= pol_in;
      end
    end
  end

  assign both_act    = (hph == PH_ACT) && (vph == PH_ACT);
  assign hsync_o     = (hph == PH_SYNC) ^ pol_q[6];
  assign vsync_o     = (vph == PH_SYNC) ^ pol_q[5];
  assign pix_data_o  = pix_data_i ^ {DW{pol_q[4]}};
  assign den_o       = both_act ^ pol_q[3];
  assign lend_o      = pol_q[1] & (((hph == PH_FRONT) && (hcnt == '0)) ^ pol_q[2]);
  assign pclk_fall_o = pol_q[0];
  assign hstat_o     = hph;
  assign vstat_o     = vph;
  assign pix_valid_o = both_act;
  assign px_x_o      = hcnt;
  assign px_y_o      = vcnt;
  assign cfg_all     = {hs_q, hb_q, ha_q, hf_q, vs_q, vb_q, va_q, vf_q, pol_q};

  AST_HPHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (hph != $past(hph)) |-> (hph == $past(hph) + 2'd1)); // R2
  AST_VSTEP_AT_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((vph != $past(vph)) || (vcnt != $past(vcnt))) |-> (($past(hph) == PH_FRONT) && (hph == PH_SYNC))); // R4
  AST_X_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && $past(pix_valid_o)) |-> (px_x_o == $past(px_x_o) + 1'b1)); // R7
  AST_X_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid_o) |-> (px_x_o == '0)); // R7
  AST_CFG_AT_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_all != $past(cfg_all)) |-> ((hph == PH_SYNC) && (vph == PH_SYNC) && (hcnt == '0) && (vcnt == '0))); // R11
endmodule

// File: tb/sim_tft_timing_gen.sv
module sim_tft_timing_gen;
  localparam int PERIOD = 10;
  localparam int SW = 8, CW = 11, DW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SW-1:0] hs;
  logic [CW-1:0] hb, ha, hf, vs, vb, va, vf;
  logic i_hs, i_vs, i_d, i_den, i_le, le_en, fall;
  logic [DW-1:0] din;
  logic hsync, vsync, den, lend, pfall, pvalid;
  logic [DW-1:0] dout;
  logic [1:0] hst, vst;
  logic [CW-1:0] px, py;

  int total = 0, bad = 0;
  bit finished = 0;

  int c_hs, c_hb, c_ha, c_hf, c_vs, c_vb, c_va, c_vf;
  bit c_ihs, c_ivs, c_id, c_iden, c_ile, c_leen, c_fall;
  int t;

  always #(PERIOD/2) clk = ~clk;

  tft_timing_gen #(.SW(SW), .CW(CW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_hsync_len(hs), .cfg_hback_len(hb), .cfg_hact_len(ha), .cfg_hfront_len(hf),
    .cfg_vsync_len(vs), .cfg_vback_len(vb), .cfg_vact_len(va), .cfg_vfront_len(vf),
    .inv_hsync(i_hs), .inv_vsync(i_vs), .inv_data(i_d), .inv_den(i_den), .inv_lend(i_le),
    .lend_en(le_en), .pclk_fall_sel(fall), .pix_data_i(din),
    .hsync_o(hsync), .vsync_o(vsync), .den_o(den), .lend_o(lend), .pclk_fall_o(pfall),
    .pix_data_o(dout), .hstat_o(hst), .vstat_o(vst), .pix_valid_o(pvalid),
    .px_x_o(px), .px_y_o(py)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0d", req, act, exp, t);
    end
  endtask

  task automatic capture();
    c_hs = hs; c_hb = hb; c_ha = ha; c_hf = hf;
    c_vs = vs; c_vb = vb; c_va = va; c_vf = vf;
    c_ihs = i_hs; c_ivs = i_vs; c_id = i_d; c_iden = i_den; c_ile = i_le;
    c_leen = le_en; c_fall = fall;
  endtask

  function automatic int htot();
    return c_hs + c_hb + c_ha + c_hf + 4;
  endfunction

  function automatic int vtot();
    return c_vs + c_vb + c_va + c_vf + 4;
  endfunction

  function automatic int phase_of(input int p, input int a, input int b, input int c);
    if (p < a + 1) return 0;
    if (p < a + b + 2) return 1;
    if (p < a + b + c + 3) return 2;
    return 3;
  endfunction

  task automatic check_all();
    int x, y, eh, ev, exx, eyy, fp_start;
    bit act, el;
    x = t % htot();
    y = t / htot();
    eh = phase_of(x, c_hs, c_hb, c_ha);
    ev = phase_of(y, c_vs, c_vb, c_va);
    act = (eh == 2) && (ev == 2);
    exx = x - (c_hs + c_hb + 2);
    eyy = y - (c_vs + c_vb + 2);
    fp_start = c_hs + c_hb + c_ha + 3;
    el = c_leen & ((x == fp_start) ^ c_ile);
    chk(hst == eh[1:0], "R2/R3 hstat", hst, eh);
    chk(vst == ev[1:0], "R4/R3 vstat", vst, ev);
    chk(hsync == ((eh == 0) ^ c_ihs), "R5 hsync", hsync, (eh == 0) ^ c_ihs);
    chk(vsync == ((ev == 0) ^ c_ivs), "R5 vsync", vsync, (ev == 0) ^ c_ivs);
    chk(den == (act ^ c_iden), "R6 den", den, act ^ c_iden);
    chk(pvalid == act, "R7 valid", pvalid, act);
    if (act) begin
      chk(px == exx[CW-1:0], "R7 px_x", px, exx);
      chk(py == eyy[CW-1:0], "R7 px_y", py, eyy);
    end
    chk(dout == (din ^ {DW{c_id}}), "R8 data", dout, din ^ {DW{c_id}});
    chk(lend == el, "R9 lend", lend, el);
    chk(pfall == c_fall, "R10 pclk edge", pfall, c_fall);
  endtask

  task automatic rand_cfg(input int span);
    hs = SW'($urandom % span); hb = CW'($urandom % span); ha = CW'($urandom % span);
    hf = CW'($urandom % span); vs = CW'($urandom % span); vb = CW'($urandom % span);
    va = CW'($urandom % span); vf = CW'($urandom % span);
    {i_hs, i_vs, i_d, i_den, i_le, le_en, fall} = 7'($urandom);
  endtask

  task automatic run(input int n, input int chg_rate);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      t++;
      if (t == htot() * vtot()) begin
        t = 0;
        capture();
      end
      @(negedge clk);
      check_all();
      din = DW'($urandom);
      if (chg_rate != 0 && ($urandom % chg_rate) == 0) rand_cfg(5);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    t = 0;
    rand_cfg(4);
    hs = 8'd2; hb = 11'd1; ha = 11'd3; hf = 11'd1; vs = 11'd0; vb = 11'd1; va = 11'd2; vf = 11'd0;
    {i_hs, i_vs, i_d, i_den, i_le, le_en, fall} = 7'b0000010;
    din = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    capture();
    t = 0;
    @(negedge clk);
    chk(hst == 2'd0, "R1 reset hstat", hst, 0);
    chk(vst == 2'd0, "R1 reset vstat", vst, 0);
    chk(hsync == 1'b1, "R1 reset hsync", hsync, 1);
    rst_n = 1'b1;
    run(300, 0);
    // R11: change config in mid-frame, old values must hold until the frame boundary
    rand_cfg(5);
    run(600, 0);
    // R2/R4: all-zero lengths, one cycle per phase
    hs = '0; hb = '0; ha = '0; hf = '0; vs = '0; vb = '0; va = '0; vf = '0;
    {i_hs, i_vs, i_d, i_den, i_le, le_en, fall} = 7'b1111111;
    run(800, 0);
    // R2: 8-bit sync length boundary
    hs = 8'd255; hb = 11'd2; ha = 11'd4; hf = 11'd1; vs = 11'd0; vb = 11'd0; va = 11'd1; vf = 11'd0;
    {i_hs, i_vs, i_d, i_den, i_le, le_en, fall} = 7'b0100110;
    run(3000, 0);
    // R9: enable off with inversion on
    {i_hs, i_vs, i_d, i_den, i_le, le_en, fall} = 7'b0000100;
    run(3000, 0);
    // random mix, config changing at arbitrary cycles
    rand_cfg(5);
    run(30000, 37);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 190000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule